// File: doc/BRIEF.md
# Interleaved Refresh Command Sequencer

This block sits on the controller side of a multi-bank packet DRAM channel and produces all of its refresh traffic. It asks for broadcast refresh-activate commands at a programmable average rate. It pairs each one with a broadcast refresh-precharge to the same bank once a programmable row-active time has passed. Banks are visited in a fixed 32-step order in which consecutive steps never land on neighbouring banks. A busy mask marks every bank that has been activated for refresh and not yet precharged, so the normal command scheduler can keep away from those banks.

The sequencer also manages the move into and out of device self-refresh. When self-refresh is requested, it issues refreshes back to back until the visit order is complete. It then waits for every precharge to be accepted before it acknowledges. When the request is withdrawn, it runs a catch-up pass over all 32 banks. The catch-up activates are spread evenly over a programmable window and start at the head of the order. Normal paced refresh then resumes.

Top module: `refresh_interleave_seq`

## Requirements
- R1: Refresh-activates visit banks in the order 12,10,5,3,0,14,9,7,4,2,13,11,8,6,1,15,28,26,21,19,16,30,25,23,20,18,29,27,24,22,17,31 and then wrap to 12. After reset the order starts at 12.
- R2: Every command is broadcast (`cmd_bcast`=1). `cmd_kind` is 0 for refresh-activate and 1 for refresh-precharge.
- R3: With `cmd_ready` high, a refresh-precharge to the same bank is requested exactly `cfg_tras` cycles after its activate is accepted. A due precharge is held until accepted and wins over a waiting activate.
- R4: `busy_mask` bit b is set from the edge that accepts an activate of bank b to the edge that accepts its precharge. No activate is ever requested to a bank whose bit is set.
- R5: In normal operation one refresh falls due every `cfg_interval` cycles. With `cmd_ready` high, activates are exactly `cfg_interval` cycles apart.
- R6: Any two consecutive refresh-activates target banks whose numbers differ by at least 2.
- R7: Refreshes that fall due while `cmd_ready` is low are held (up to 3). Each is issued once commands are accepted again.
- R8: While `sr_req` is high, activates are issued without waiting for the interval until bank 31 has been accepted. `sr_ack` rises only after that and after all precharges are accepted. No command is requested while `sr_ack` is high. If the order is already complete (including just after reset), `sr_ack` follows at once with no activate.
- R9: When `sr_req` falls while `sr_ack` is high, a catch-up pass issues all 32 activates from bank 12 to bank 31. The activates are spaced `cfg_burst`/32 cycles (rounded down) apart, so the pass fits inside `cfg_burst` cycles.
- R10: After the catch-up pass, the first normal activate (bank 12) is requested `cfg_interval` cycles after the edge that accepts the bank-31 catch-up activate.
- R11: During and just after reset, no command is requested, `sr_ack` is low and `busy_mask` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | CNT_W | Cycles between refresh due points |
| cfg_tras | input | CNT_W | Activate-to-precharge delay in cycles |
| cfg_burst | input | CNT_W | Catch-up window length in cycles |
| sr_req | input | 1 | Request to enter device self-refresh (level) |
| sr_ack | output | 1 | Order complete and idle; device may enter self-refresh |
| cmd_valid | output | 1 | A refresh command is requested |
| cmd_ready | input | 1 | Command accepted at this edge when valid |
| cmd_kind | output | 1 | 0 = refresh-activate, 1 = refresh-precharge |
| cmd_bank | output | 5 | Target bank |
| cmd_bcast | output | 1 | Broadcast flag, always set |
| busy_mask | output | 32 | Banks between refresh-activate and refresh-precharge |

## Verification
The bench samples on the falling edge and counts the rising edges between events. It records the edge on which each grant is seen and compares that count against the due time. A precharge is due `cfg_tras` samples after its activate. A paced activate is due `cfg_interval` samples after the previous one. A catch-up activate is due `cfg_burst`/32 samples after the previous one. The first activate after catch-up is due `cfg_interval`+1 samples after the bank-31 sample, because the timer restarts on the accepting edge. The busy mask is compared with a model every cycle, and the model is updated only after the compare, so each bit is expected one sample after the grant that sets or clears it. Around the stall, the exact-spacing checks give way to a count of the activates released in a fixed ten-cycle window.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

    localparam int NUM_BANKS = 32;
    localparam int BANK_W    = $clog2(NUM_BANKS);

    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic {
        CMD_ACT = 1'b0,
        CMD_PRE = 1'b1
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_DRAIN,
        ST_SELF,
        ST_CATCH
    } seq_state_e;

    // Position in the visit order -> bank. The upper half repeats the
    // lower-half pattern with the top bank bit set.
    function automatic bank_t visit_bank(input bank_t pos);
        logic [3:0] lo;
        case (pos[3:0])
            4'd0:  lo = 4'd12;
            4'd1:  lo = 4'd10;
            4'd2:  lo = 4'd5;
            4'd3:  lo = 4'd3;
            4'd4:  lo = 4'd0;
            4'd5:  lo = 4'd14;
            4'd6:  lo = 4'd9;
            4'd7:  lo = 4'd7;
            4'd8:  lo = 4'd4;
            4'd9:  lo = 4'd2;
            4'd10: lo = 4'd13;
            4'd11: lo = 4'd11;
            4'd12: lo = 4'd8;
            4'd13: lo = 4'd6;
            4'd14: lo = 4'd1;
            default: lo = 4'd15;
        endcase
        return {pos[BANK_W-1], lo};
    endfunction

endpackage

// File: rtl/refseq_credit_timer.sv
module refseq_credit_timer
    import refseq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int CREDIT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic             take_i,
    input  logic [CNT_W-1:0] interval_i,
    output logic             avail_o
);

    localparam logic [CREDIT_W-1:0] CREDIT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [CREDIT_W-1:0] credit;
    } tmr_t;

    tmr_t             q, d;
    logic             tick;
    logic             use_credit;
    logic [CNT_W-1:0] limit;

    always_comb begin
        d          = q;
        tick       = 1'b0;
        use_credit = take_i && (q.credit != '0);
        limit      = (interval_i == '0) ? '0 : interval_i - CNT_W'(1);
        if (clear_i) begin
            d.cnt    = '0;
            d.credit = '0;
        end else begin
            if (run_i) begin
                if (q.cnt >= limit) begin
                    d.cnt = '0;
                    tick  = 1'b1;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            case ({tick, use_credit})
                2'b10: if (q.credit != CREDIT_MAX) d.credit = q.credit + CREDIT_W'(1);
                2'b01: d.credit = q.credit - CREDIT_W'(1);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign avail_o = (q.credit != '0);

    // R7: a pending refresh stays pending until it is taken or cleared
    a_r7_credit_held: assert property (@(posedge clk) disable iff (!rst_n)
        (avail_o && !take_i && !clear_i) |=> avail_o);

endmodule

// File: rtl/refseq_pre_queue.sv
module refseq_pre_queue
    import refseq_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_i,
    input  bank_t                push_bank_i,
    input  logic [CNT_W-1:0]     tras_i,
    input  logic                 pop_i,
    output logic                 due_o,
    output bank_t                head_bank_o,
    output logic                 full_o,
    output logic                 empty_o,
    output logic [NUM_BANKS-1:0] busy_o
);

    typedef struct packed {
        logic             vld;
        bank_t            bank;
        logic [CNT_W-1:0] tmr;
    } slot_t;

    typedef slot_t [DEPTH-1:0] slots_t;

    slots_t           q, d, aged;
    logic             placed;
    logic [CNT_W-1:0] load;

    always_comb begin
        load = (tras_i == '0) ? '0 : tras_i - CNT_W'(1);
        for (int i = 0; i < DEPTH; i++) begin
            aged[i] = q[i];
            if (q[i].vld && q[i].tmr != '0) aged[i].tmr = q[i].tmr - CNT_W'(1);
        end
        d = aged;
        if (pop_i) begin
            for (int i = 0; i < DEPTH - 1; i++) d[i] = aged[i+1];
            d[DEPTH-1] = '0;
        end
        placed = 1'b0;
        if (push_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!placed && !d[i].vld) begin
                    d[i].vld  = 1'b1;
                    d[i].bank = push_bank_i;
                    d[i].tmr  = load;
                    placed    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign due_o       = q[0].vld && (q[0].tmr == '0);
    assign head_bank_o = q[0].bank;
    assign full_o      = q[DEPTH-1].vld;
    assign empty_o     = !q[0].vld;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_busy
        logic [DEPTH-1:0] hit;
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            assign hit[i] = q[i].vld && (q[i].bank == bank_t'(b));
        end
        assign busy_o[b] = |hit;
    end

    // R3: no entry is lost to an overflow
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    // R3: a precharge leaves the queue only once its delay has run out
    a_r3_pop_when_due: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> due_o);
    // R4: a bank already under refresh is never activated again
    a_r4_no_double_open: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !busy_o[push_bank_i]);
    // R4: the mask never holds more banks than there are slots
    a_r4_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy_o) <= DEPTH);

endmodule

// File: rtl/refresh_interleave_seq.sv
module refresh_interleave_seq
    import refseq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int QDEPTH   = 2,
    parameter int CREDIT_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     cfg_interval,
    input  logic [CNT_W-1:0]     cfg_tras,
    input  logic [CNT_W-1:0]     cfg_burst,
    input  logic                 sr_req,
    output logic                 sr_ack,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic                 cmd_kind,
    output logic [BANK_W-1:0]    cmd_bank,
    output logic                 cmd_bcast,
    output logic [NUM_BANKS-1:0] busy_mask
);

    localparam bank_t LAST_POS = bank_t'(NUM_BANKS - 1);

    typedef struct packed {
        seq_state_e       state;
        bank_t            idx;
        logic [CNT_W-1:0] gap;
        bank_t            last_bank;
        logic             last_vld;
    } seq_t;

    seq_t             q, d;
    logic             credit_avail;
    logic             pre_due, q_full, q_empty;
    bank_t            pre_bank;
    logic             act_ok, act_want, fire, act_fire, pre_fire;
    logic             tmr_run, tmr_clear;
    logic [CNT_W-1:0] burst_gap, gap_load;
    bank_t            bank_dist;

    always_comb begin
        burst_gap = cfg_burst >> BANK_W;
        gap_load  = (burst_gap == '0) ? '0 : burst_gap - CNT_W'(1);

        unique case (q.state)
            ST_RUN:   act_ok = credit_avail;
            ST_DRAIN: act_ok = (q.idx != '0);
            ST_CATCH: act_ok = (q.gap == '0);
            default:  act_ok = 1'b0;
        endcase
        act_want  = act_ok && !q_full;

        cmd_valid = pre_due || act_want;
        cmd_kind  = pre_due ? CMD_PRE : CMD_ACT;
        cmd_bank  = pre_due ? pre_bank : visit_bank(q.idx);
        cmd_bcast = 1'b1;
        fire      = cmd_valid && cmd_ready;
        act_fire  = fire && !pre_due;
        pre_fire  = fire && pre_due;

        tmr_run   = (q.state == ST_RUN) || (q.state == ST_DRAIN);
        tmr_clear = (q.state == ST_SELF) || (q.state == ST_CATCH);

        d = q;
        if (act_fire) begin
            d.idx       = q.idx + bank_t'(1);
            d.last_bank = cmd_bank;
            d.last_vld  = 1'b1;
        end

        if (q.state == ST_CATCH) begin
            if (act_fire)          d.gap = gap_load;
            else if (q.gap != '0)  d.gap = q.gap - CNT_W'(1);
        end else begin
            d.gap = '0;
        end

        unique case (q.state)
            ST_RUN:   if (sr_req) d.state = ST_DRAIN;
            ST_DRAIN: begin
                if (!sr_req)                       d.state = ST_RUN;
                else if (q.idx == '0 && q_empty)   d.state = ST_SELF;
            end
            ST_SELF:  if (!sr_req) d.state = ST_CATCH;
            default:  if (act_fire && q.idx == LAST_POS) d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: ST_RUN, idx: '0, gap: '0, last_bank: '0, last_vld: 1'b0};
        else        q <= d;
    end

    assign sr_ack = (q.state == ST_SELF);

    refseq_credit_timer #(
        .CNT_W   (CNT_W),
        .CREDIT_W(CREDIT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tmr_run),
        .clear_i   (tmr_clear),
        .take_i    (act_fire && tmr_run),
        .interval_i(cfg_interval),
        .avail_o   (credit_avail)
    );

    refseq_pre_queue #(
        .DEPTH(QDEPTH),
        .CNT_W(CNT_W)
    ) u_preq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (act_fire),
        .push_bank_i(cmd_bank),
        .tras_i     (cfg_tras),
        .pop_i      (pre_fire),
        .due_o      (pre_due),
        .head_bank_o(pre_bank),
        .full_o     (q_full),
        .empty_o    (q_empty),
        .busy_o     (busy_mask)
    );

    assign bank_dist = (cmd_bank > q.last_bank) ? cmd_bank - q.last_bank
                                                : q.last_bank - cmd_bank;

    // R6: consecutive activates never hit neighbouring banks
    a_r6_bank_spread: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fire && q.last_vld) |-> (bank_dist >= bank_t'(2)));
    // R4: an activate never targets a bank that is still open
    a_r4_act_free_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_ACT) |-> !busy_mask[cmd_bank]);
    // R8: acknowledge only with every bank closed and the command port silent
    a_r8_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sr_ack |-> (busy_mask == '0 && !cmd_valid));
    // R9: the cycle after wake starts the catch-up pass at bank 12
    a_r9_wake_at_head: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_ack) |-> (cmd_valid && cmd_kind == CMD_ACT && cmd_bank == bank_t'(12)));
    // R2: every command is broadcast
    a_r2_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_bcast);

endmodule

// File: tb/refresh_interleave_seq_bench.sv
module refresh_interleave_seq_bench;

    localparam int CW       = 16;
    localparam int INTERVAL = 20;
    localparam int TRAS     = 5;
    localparam int BURST    = 96;
    localparam int GAP      = BURST / 32;
    localparam int ORDER [32] = '{12, 10, 5, 3, 0, 14, 9, 7, 4, 2, 13, 11, 8, 6, 1, 15,
                                  28, 26, 21, 19, 16, 30, 25, 23, 20, 18, 29, 27, 24, 22, 17, 31};
    localparam int M_FREE = 0, M_STEADY = 1, M_CATCH = 2, M_AFTER = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sr_req, sr_ack, cmd_valid, cmd_ready, cmd_kind, cmd_bcast;
    logic [4:0]    cmd_bank;
    logic [31:0]   busy_mask;

    refresh_interleave_seq u_refresh_interleave_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_interval(CW'(INTERVAL)), .cfg_tras(CW'(TRAS)), .cfg_burst(CW'(BURST)),
        .sr_req(sr_req), .sr_ack(sr_ack),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_bank(cmd_bank), .cmd_bcast(cmd_bcast), .busy_mask(busy_mask)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    int          mode = M_FREE;
    int          exp_idx = 0, total_acts = 0, catch_n = 0, catch_start = 0, t_last_catch = 0;
    int          last_act = 0, last_bank = 0, win_acts = 0;
    bit          have_last = 0, have_bank = 0, loose = 0, win_open = 0, prev_ack = 0;
    int          act_cyc [32];
    logic [31:0] model = '0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(busy_mask == model, "R4 busy mask", int'(busy_mask), int'(model));
            if (sr_ack) check(!cmd_valid, "R8 silent while acknowledged", int'(cmd_valid), 0);
            if (sr_ack && !prev_ack) begin
                check(exp_idx == 0, "R8 order complete at ack", exp_idx, 0);
                check(model == '0, "R8 precharges done at ack", int'(model), 0);
            end
            prev_ack = sr_ack;
            if (cmd_valid && cmd_ready) begin
                check(cmd_bcast, "R2 broadcast", int'(cmd_bcast), 1);
                if (cmd_kind == 1'b0) begin
                    check(int'(cmd_bank) == ORDER[exp_idx], "R1 visit order", int'(cmd_bank), ORDER[exp_idx]);
                    check(!model[cmd_bank], "R4 activate to free bank", int'(model[cmd_bank]), 0);
                    if (have_bank)
                        check((int'(cmd_bank) - last_bank >= 2) || (last_bank - int'(cmd_bank) >= 2),
                              "R6 bank spread", int'(cmd_bank), last_bank);
                    case (mode)
                        M_STEADY: begin
                            if (have_last) check(cyc - last_act == INTERVAL, "R5 interval", cyc - last_act, INTERVAL);
                            have_last = 1;
                        end
                        M_CATCH: begin
                            if (catch_n == 0) begin
                                check(exp_idx == 0, "R9 catch-up starts at head", exp_idx, 0);
                                catch_start = cyc;
                            end else begin
                                check(cyc - last_act == GAP, "R9 catch-up spacing", cyc - last_act, GAP);
                            end
                            catch_n++;
                            if (catch_n == 32) begin
                                check(cmd_bank == 5'd31, "R9 catch-up ends at 31", int'(cmd_bank), 31);
                                check(cyc - catch_start <= BURST, "R9 pass inside window", cyc - catch_start, BURST);
                                t_last_catch = cyc;
                                mode = M_AFTER;
                            end
                        end
                        M_AFTER: begin
                            check(cyc - (t_last_catch + 1) == INTERVAL, "R10 resume delay",
                                  cyc - (t_last_catch + 1), INTERVAL);
                            check(cmd_bank == 5'd12, "R10 resume at 12", int'(cmd_bank), 12);
                            have_last = 1;
                            mode = M_STEADY;
                        end
                        default: ;
                    endcase
                    if (win_open) win_acts++;
                    last_act = cyc;
                    last_bank = int'(cmd_bank);
                    have_bank = 1;
                    act_cyc[cmd_bank] = cyc;
                    model[cmd_bank] = 1'b1;
                    exp_idx = (exp_idx + 1) % 32;
                    total_acts++;
                end else begin
                    check(model[cmd_bank], "R3 precharge matches open bank", int'(model[cmd_bank]), 1);
                    if (loose)
                        check(cyc - act_cyc[cmd_bank] >= TRAS, "R3 precharge not early",
                              cyc - act_cyc[cmd_bank], TRAS);
                    else
                        check(cyc - act_cyc[cmd_bank] == TRAS, "R3 precharge delay",
                              cyc - act_cyc[cmd_bank], TRAS);
                    model[cmd_bank] = 1'b0;
                end
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic wait_act();
        do @(negedge clk); while (!(cmd_valid && cmd_ready && cmd_kind == 1'b0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end

    initial begin
        cmd_ready = 1'b1;
        sr_req    = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(!cmd_valid && !sr_ack && busy_mask == '0, "R11 reset state",
                  int'(cmd_valid) + int'(sr_ack), 0);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R8 boundary: order already complete at reset, ack with no activate
        for (int i = 0; i < 5 && !sr_ack; i++) @(negedge clk);
        check(sr_ack, "R8 immediate ack after reset", int'(sr_ack), 1);
        check(total_acts == 0, "R8 no activate before ack", total_acts, 0);
        repeat (10) @(negedge clk);

        // R9/R10: wake, catch-up pass, then paced refresh through a wrap
        mode = M_CATCH;
        catch_n = 0;
        @(posedge clk);
        #1 sr_req = 1'b0;
        while (total_acts < 68) @(negedge clk);
        check(mode == M_STEADY, "R10 back in paced mode", mode, M_STEADY);

        // R7: stall the port across two due points
        wait_act();
        @(posedge clk);
        #1 cmd_ready = 1'b0;
        mode = M_FREE;
        loose = 1;
        repeat (45) @(posedge clk);
        #1 cmd_ready = 1'b1;
        win_acts = 0;
        win_open = 1;
        repeat (10) @(negedge clk);
        win_open = 0;
        check(win_acts == 2, "R7 held refreshes released", win_acts, 2);
        loose = 0;
        have_last = 0;
        mode = M_STEADY;
        while (total_acts < 76) @(negedge clk);

        // R8: self-refresh request in the middle of the order
        wait_act();
        @(posedge clk);
        #1 sr_req = 1'b1;
        mode = M_FREE;
        for (int i = 0; i < 300 && !sr_ack; i++) @(negedge clk);
        check(sr_ack, "R8 ack after drain", int'(sr_ack), 1);
        repeat (20) @(negedge clk);

        mode = M_CATCH;
        catch_n = 0;
        @(posedge clk);
        #1 sr_req = 1'b0;
        while (!(mode == M_STEADY && catch_n == 32)) @(negedge clk);
        begin
            int target = total_acts + 3;
            while (total_acts < target) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule